// File: doc/BRIEF.md
# Erase-Program-Verify Update Sequencer

This block runs a complete rewrite of a byte-wide, electrically erasable, one-time-writable memory array through its control pins. The memory's supply levels are reduced to logic-level requests. After a start strobe the sequencer first applies one whole-array erase pulse. It then reads every location back and checks that it holds all ones. Next it pulls one byte per address from a valid/ready source stream, applies a program pulse for that byte and reads the byte back at once to check it. A byte that reads back wrong gets further program pulses, up to a configured limit.

Erase and program pulse widths come from configuration inputs and are counted in clock cycles. If the erase check fails, one more whole-array erase is applied before the sequencer gives up. If a check fails for good, the sequencer stops, raises `error` and reports the failing address. If every address from zero to the top passes, it raises `done`. Either flag holds until the next start.

Top module: `nvm_update_seq`

## Requirements
- R1: One cycle after a start strobe is accepted, the sequencer applies a whole-array erase. During the erase, `mem_hv_lvl` is 2 (erase level), `mem_a9_hv` is high, `mem_addr` is zero and `mem_dout` is all ones with `mem_dout_en` high. `mem_ce_n` is low for exactly `cfg_erase_len` cycles, and a value of 0 counts as 1.
- R2: After each erase, locations are read in ascending order starting at zero. A read holds `mem_ce_n` and `mem_oe_n` low, `mem_hv_lvl` at 0 (off) and `mem_dout_en` low for two cycles per location. `mem_din` is sampled in the second cycle and must be all ones.
- R3: On the first failed erase check, the sequencer restarts the erase (R1) and then the check from address zero. A failure after that second erase ends the run with `error` high and `err_addr` set to the failing address, and no programming takes place.
- R4: `src_ready` is high only while the sequencer waits for the next byte, with the memory bus idle. Exactly one byte is taken per address, in ascending address order, on a cycle where `src_valid` and `src_ready` are both high.
- R5: Each program pulse holds `mem_hv_lvl` at 1 (program level), `mem_addr` at the target address and `mem_dout` at the source byte, with `mem_dout_en` high and `mem_oe_n` high. `mem_ce_n` is low for exactly `cfg_prog_len` cycles, and a value of 0 counts as 1.
- R6: Every program pulse is followed by a two-cycle read of the same address, as in R2. If the byte read back differs from the source byte, the pulse is repeated, up to `cfg_retry_max` extra pulses per address.
- R7: If an address still fails after `cfg_retry_max` extra pulses, `error` rises and `err_addr` holds that address. The sequencer then applies no further pulses and takes no more bytes until the next start.
- R8: `done` rises after the top address verifies. `done` and `error` are never high together. Both flags stay unchanged until a new start is accepted, and both fall one cycle after that start.
- R9: `mem_ce_n` and `mem_oe_n` are never low together while `mem_hv_lvl` is not 0.
- R10: While `rst_n` is low at a clock edge, the outputs go to the idle state: `mem_ce_n` and `mem_oe_n` high, `mem_hv_lvl` 0, `mem_dout_en`, `src_ready`, `done` and `error` low.
- R11: A start strobe that arrives while a run is in progress has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, accepted when no run is in progress |
| cfg_erase_len | input | PULSE_W | Erase pulse width in cycles |
| cfg_prog_len | input | PULSE_W | Program pulse width in cycles |
| cfg_retry_max | input | RETRY_W | Extra program pulses allowed per address |
| src_data | input | DATA_W | Source byte |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Sequencer takes a byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data driven to the memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low, used as the pulse strobe |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_hv_lvl | output | 2 | Output-enable supply level request: 0 off, 1 program, 2 erase |
| mem_a9_hv | output | 1 | High-voltage request on the erase-select address line |
| done | output | 1 | Run finished with every byte verified |
| error | output | 1 | Run stopped on a verify failure |
| err_addr | output | ADDR_W | Address of the failing location |

## Verification
The assertions assume that the configuration inputs stay constant during a run. They also assume that `mem_din` shows the addressed byte by the second read cycle, and that `start` is a single-cycle strobe. The bench sets the configuration before each start and leaves it alone until the run ends. Its memory model answers reads combinationally from its array and changes contents only at the end of a strobe pulse. Failures are injected by pulses that have no effect and by an erase that leaves one location short. No pin is driven outside these assumptions.

// File: rtl/nvm_update_pkg.sv
// Shared types for the update sequencer.
// Assumes: the supply-level requests are plain codes decoded outside the block.
package nvm_update_pkg;

    localparam logic [1:0] HV_OFF   = 2'd0;
    localparam logic [1:0] HV_PROG  = 2'd1;
    localparam logic [1:0] HV_ERASE = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ER_SET,
        ST_ER_PUL,
        ST_ER_HLD,
        ST_EV_SET,
        ST_EV_RD,
        ST_PG_GET,
        ST_PG_SET,
        ST_PG_PUL,
        ST_PG_HLD,
        ST_PV_SET,
        ST_PV_RD,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic       ce_n;
        logic       oe_n;
        logic [1:0] hv;
        logic       a9;
        logic       dout_en;
        logic       src_ready;
        logic       done;
        logic       error;
    } pin_drive_t;

endpackage

// File: rtl/nvm_pulse_timer.sv
// Down-counter that times a strobe pulse in clock cycles.
// Assumes: load is a single cycle; after load, expired rises once len cycles
// (len 0 treated as 1) have been counted, counting the first cycle after load.
module nvm_pulse_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load the remaining length, then count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len == '0) ? '0 : len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvm_addr_ctr.sv
// Ascending address counter for the erase check and the program pass.
// Assumes: clr has priority over inc.
module nvm_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    logic [ADDR_W-1:0] addr_q;

    // Hold, clear or step the current address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clr) begin
            addr_q <= '0;
        end else if (inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = &addr_q;

endmodule

// File: rtl/nvm_retry_ctr.sv
// Counts extra program pulses spent on the current address.
// Assumes: clr at each new address; hit means no further pulse is allowed.
module nvm_retry_ctr #(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    input  logic [RETRY_W-1:0] limit,
    output logic               hit
);

    logic [RETRY_W-1:0] cnt_q;

    // Track retries taken for this address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = (cnt_q == limit);

endmodule

// File: rtl/nvm_seq_fsm.sv
// Control state machine for erase, erase check, program and program check.
// Pin drives are registered from the next-state decode, so every pin is glitch
// free and matches the state register in the same cycle.
// Assumes: rd_ok is valid in the read states; tmr_exp, addr_last and rty_hit
// come from registered counters.
module nvm_seq_fsm
    import nvm_update_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       src_valid,
    input  logic       rd_ok,
    input  logic       tmr_exp,
    input  logic       addr_last,
    input  logic       rty_hit,
    output pin_drive_t pins,
    output logic       tmr_load,
    output logic       tmr_erase,
    output logic       addr_clr,
    output logic       addr_inc,
    output logic       rty_clr,
    output logic       rty_inc,
    output logic       byte_load,
    output logic       err_latch,
    output logic       chk_erased
);

    seq_state_e state_q, state_d;
    logic       ers_retried_q, ers_retried_d;
    pin_drive_t pins_q;

    // Pin levels that belong to each state.
    function automatic pin_drive_t decode(input seq_state_e st);
        pin_drive_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, hv: HV_OFF, a9: 1'b0, dout_en: 1'b0,
              src_ready: 1'b0, done: 1'b0, error: 1'b0};
        case (st)
            ST_ER_SET, ST_ER_HLD: begin
                p.hv = HV_ERASE; p.a9 = 1'b1; p.dout_en = 1'b1;
            end
            ST_ER_PUL: begin
                p.hv = HV_ERASE; p.a9 = 1'b1; p.dout_en = 1'b1; p.ce_n = 1'b0;
            end
            ST_EV_SET, ST_EV_RD, ST_PV_SET, ST_PV_RD: begin
                p.ce_n = 1'b0; p.oe_n = 1'b0;
            end
            ST_PG_SET, ST_PG_HLD: begin
                p.hv = HV_PROG; p.dout_en = 1'b1;
            end
            ST_PG_PUL: begin
                p.hv = HV_PROG; p.dout_en = 1'b1; p.ce_n = 1'b0;
            end
            ST_PG_GET: p.src_ready = 1'b1;
            ST_DONE:   p.done = 1'b1;
            ST_FAIL:   p.error = 1'b1;
            default:   p = p;
        endcase
        return p;
    endfunction

    // Next state and the strobes to the counters.
    always_comb begin
        state_d       = state_q;
        ers_retried_d = ers_retried_q;
        tmr_load      = 1'b0;
        tmr_erase     = 1'b0;
        addr_clr      = 1'b0;
        addr_inc      = 1'b0;
        rty_clr       = 1'b0;
        rty_inc       = 1'b0;
        byte_load     = 1'b0;
        err_latch     = 1'b0;
        case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    state_d       = ST_ER_SET;
                    ers_retried_d = 1'b0;
                    addr_clr      = 1'b1;
                end
            end
            ST_ER_SET: begin
                tmr_load  = 1'b1;
                tmr_erase = 1'b1;
                state_d   = ST_ER_PUL;
            end
            ST_ER_PUL: if (tmr_exp) state_d = ST_ER_HLD;
            ST_ER_HLD: state_d = ST_EV_SET;
            ST_EV_SET: state_d = ST_EV_RD;
            ST_EV_RD: begin
                if (!rd_ok) begin
                    if (!ers_retried_q) begin
                        ers_retried_d = 1'b1;
                        addr_clr      = 1'b1;
                        state_d       = ST_ER_SET;
                    end else begin
                        err_latch = 1'b1;
                        state_d   = ST_FAIL;
                    end
                end else if (addr_last) begin
                    addr_clr = 1'b1;
                    state_d  = ST_PG_GET;
                end else begin
                    addr_inc = 1'b1;
                    state_d  = ST_EV_SET;
                end
            end
            ST_PG_GET: begin
                if (src_valid) begin
                    byte_load = 1'b1;
                    rty_clr   = 1'b1;
                    state_d   = ST_PG_SET;
                end
            end
            ST_PG_SET: begin
                tmr_load = 1'b1;
                state_d  = ST_PG_PUL;
            end
            ST_PG_PUL: if (tmr_exp) state_d = ST_PG_HLD;
            ST_PG_HLD: state_d = ST_PV_SET;
            ST_PV_SET: state_d = ST_PV_RD;
            ST_PV_RD: begin
                if (rd_ok) begin
                    if (addr_last) begin
                        state_d = ST_DONE;
                    end else begin
                        addr_inc = 1'b1;
                        state_d  = ST_PG_GET;
                    end
                end else if (rty_hit) begin
                    err_latch = 1'b1;
                    state_d   = ST_FAIL;
                end else begin
                    rty_inc = 1'b1;
                    state_d = ST_PG_SET;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, erase-retry flag and registered pin drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            ers_retried_q <= 1'b0;
            pins_q        <= decode(ST_IDLE);
        end else begin
            state_q       <= state_d;
            ers_retried_q <= ers_retried_d;
            pins_q        <= decode(state_d);
        end
    end

    assign pins       = pins_q;
    assign chk_erased = (state_q == ST_EV_RD);

endmodule

// File: rtl/nvm_update_seq.sv
// Top of the update sequencer: erases the whole array, checks it, then
// programs and checks one streamed byte per ascending address.
// Assumes: cfg_* stay constant during a run; mem_din shows the addressed byte
// by the second cycle of a read.
module nvm_update_seq
    import nvm_update_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int PULSE_W = 16,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PULSE_W-1:0] cfg_erase_len,
    input  logic [PULSE_W-1:0] cfg_prog_len,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic [DATA_W-1:0]  src_data,
    input  logic               src_valid,
    output logic               src_ready,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_dout,
    output logic               mem_dout_en,
    input  logic [DATA_W-1:0]  mem_din,
    output logic               mem_ce_n,
    output logic               mem_oe_n,
    output logic [1:0]         mem_hv_lvl,
    output logic               mem_a9_hv,
    output logic               done,
    output logic               error,
    output logic [ADDR_W-1:0]  err_addr
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    pin_drive_t         pins;
    logic               tmr_load, tmr_erase, tmr_exp;
    logic               addr_clr, addr_inc, addr_last;
    logic               rty_clr, rty_inc, rty_hit;
    logic               byte_load, err_latch, chk_erased, rd_ok;
    logic [ADDR_W-1:0]  addr;
    logic [PULSE_W-1:0] tmr_len;
    logic [DATA_W-1:0]  byte_q;
    logic [ADDR_W-1:0]  err_addr_q;

    assign tmr_len = tmr_erase ? cfg_erase_len : cfg_prog_len;
    assign rd_ok   = (mem_din == (chk_erased ? ALL_ONES : byte_q));

    nvm_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .src_valid  (src_valid),
        .rd_ok      (rd_ok),
        .tmr_exp    (tmr_exp),
        .addr_last  (addr_last),
        .rty_hit    (rty_hit),
        .pins       (pins),
        .tmr_load   (tmr_load),
        .tmr_erase  (tmr_erase),
        .addr_clr   (addr_clr),
        .addr_inc   (addr_inc),
        .rty_clr    (rty_clr),
        .rty_inc    (rty_inc),
        .byte_load  (byte_load),
        .err_latch  (err_latch),
        .chk_erased (chk_erased)
    );

    nvm_pulse_timer #(.CNT_W(PULSE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_exp)
    );

    nvm_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .inc   (addr_inc),
        .addr  (addr),
        .last  (addr_last)
    );

    nvm_retry_ctr #(.RETRY_W(RETRY_W)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rty_clr),
        .inc   (rty_inc),
        .limit (cfg_retry_max),
        .hit   (rty_hit)
    );

    // Capture the source byte when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (byte_load) begin
            byte_q <= src_data;
        end
    end

    // Record the address of a final verify failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr_q <= '0;
        end else if (err_latch) begin
            err_addr_q <= addr;
        end
    end

    assign mem_addr    = addr;
    assign mem_dout    = (pins.hv == HV_ERASE) ? ALL_ONES : byte_q;
    assign mem_dout_en = pins.dout_en;
    assign mem_ce_n    = pins.ce_n;
    assign mem_oe_n    = pins.oe_n;
    assign mem_hv_lvl  = pins.hv;
    assign mem_a9_hv   = pins.a9;
    assign src_ready   = pins.src_ready;
    assign done        = pins.done;
    assign error       = pins.error;
    assign err_addr    = err_addr_q;

endmodule

// File: rtl/nvm_update_seq_chk.sv
// Port-level properties of the update sequencer, bound to every instance.
// Assumes: start is a single-cycle strobe and configuration is stable per run.
module nvm_update_seq_chk
    import nvm_update_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int PULSE_W = 16,
    parameter int RETRY_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              src_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic [1:0]        mem_hv_lvl,
    input logic              mem_a9_hv,
    input logic              done,
    input logic              error
);

    // R9: no read while a high level is requested
    a_r9_no_read_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_oe_n) |-> (mem_hv_lvl == HV_OFF));

    // R1: erase conditions on address and data pins
    a_r1_erase_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_hv_lvl == HV_ERASE) |->
            (mem_a9_hv && mem_addr == '0 && mem_dout_en && mem_dout == {DATA_W{1'b1}}));

    // R5: program level only with data driven and outputs disabled
    a_r5_prog_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_hv_lvl == HV_PROG) |-> (mem_dout_en && mem_oe_n && !mem_a9_hv));

    // R2: the data bus is released whenever the memory may drive it
    a_r2_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en);

    // R4: a byte is only requested while the memory bus is idle
    a_r4_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (mem_ce_n && mem_hv_lvl == HV_OFF));

    // R8: the two result flags exclude each other
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R8: done holds until a new start
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R7: after a failure the memory and the source stay quiet
    a_r7_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> (error && mem_ce_n && !src_ready));

endmodule

bind nvm_update_seq nvm_update_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PULSE_W(PULSE_W),
    .RETRY_W(RETRY_W)
) chk_i (.*);

// File: tb/nvm_update_seq_tb_top.sv
module nvm_update_seq_tb_top;
    import nvm_update_pkg::*;

    localparam int AW = 3;
    localparam int DW = 8;
    localparam int PW = 16;
    localparam int RW = 4;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] cfg_erase_len = 16'd1;
    logic [PW-1:0] cfg_prog_len = 16'd1;
    logic [RW-1:0] cfg_retry_max = '0;
    logic [DW-1:0] src_data;
    logic          src_valid;
    logic          src_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_en;
    logic [DW-1:0] mem_din;
    logic          mem_ce_n, mem_oe_n, mem_a9_hv;
    logic [1:0]    mem_hv_lvl;
    logic          done, error;
    logic [AW-1:0] err_addr;

    nvm_update_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_W(PW), .RETRY_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_erase_len(cfg_erase_len), .cfg_prog_len(cfg_prog_len),
        .cfg_retry_max(cfg_retry_max),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_hv_lvl(mem_hv_lvl), .mem_a9_hv(mem_a9_hv),
        .done(done), .error(error), .err_addr(err_addr)
    );

    // Stimulus and expected-result vectors: the expectations are derived per row.
    typedef struct packed {
        logic [7:0]  seed;   // source stream seed
        logic [2:0]  wa;     // address with ineffective program pulses
        logic [3:0]  wcnt;   // how many pulses there have no effect
        logic [1:0]  ef;     // erase pulses that leave one location short
        logic [2:0]  efa;    // location left short
        logic [3:0]  rty;    // retry limit
        logic [15:0] plen;   // program pulse width
        logic [15:0] elen;   // erase pulse width
        logic        gap;    // source valid only one cycle in four
    } case_t;

    localparam int NC = 7;
    localparam case_t CASES [NC] = '{
        '{8'h11, 3'd0, 4'd0, 2'd0, 3'd0, 4'd2, 16'd3, 16'd5, 1'b0},
        '{8'hA3, 3'd5, 4'd2, 2'd0, 3'd0, 4'd2, 16'd1, 16'd0, 1'b1},
        '{8'h3C, 3'd2, 4'd3, 2'd0, 3'd0, 4'd2, 16'd2, 16'd2, 1'b0},
        '{8'h77, 3'd0, 4'd0, 2'd1, 3'd6, 4'd1, 16'd4, 16'd7, 1'b0},
        '{8'h90, 3'd0, 4'd0, 2'd2, 3'd3, 4'd1, 16'd2, 16'd3, 1'b1},
        '{8'h42, 3'd7, 4'd1, 2'd0, 3'd0, 4'd0, 16'd2, 16'd2, 1'b0},
        '{8'h5D, 3'd1, 4'd1, 2'd0, 3'd0, 4'd1, 16'd0, 16'd1, 1'b1}
    };

    int tests = 0;
    int fails = 0;

    // Model configuration (written only by tasks) and model state.
    logic [7:0] cur_seed = 8'h00;
    logic [2:0] cur_wa = '0, cur_efa = '0;
    int         cur_wcnt = 0, cur_ef = 0, exp_elen = 1, exp_plen = 1;
    logic       cur_gap = 1'b0;
    logic       clr_req = 1'b0;

    logic [7:0] mem [N];
    int weak_left, erase_left, er_pulses, pg_pulses, bad_len, viol, ev_reads, cur_len;
    logic [1:0] low_hv;
    logic       prev_ce;
    int         idx;
    logic [7:0] cyc;

    function automatic logic [7:0] stream_byte(input logic [7:0] seed, input int a);
        return (seed + 8'(a * 53)) ^ 8'h5A;
    endfunction

    assign mem_din   = (!mem_ce_n && !mem_oe_n && mem_hv_lvl == HV_OFF) ? mem[mem_addr] : 8'h00;
    assign src_data  = stream_byte(cur_seed, idx);
    assign src_valid = !(cur_gap && cyc[1:0] != 2'b11);

    // Memory model and pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (clr_req) begin
            for (int a = 0; a < N; a++) mem[a] = 8'h00;
            weak_left = cur_wcnt; erase_left = cur_ef;
            er_pulses = 0; pg_pulses = 0; bad_len = 0; viol = 0; ev_reads = 0;
            cur_len = 0; prev_ce = 1'b1; low_hv = HV_OFF;
        end else begin
            if (!mem_ce_n && !mem_oe_n && (mem_hv_lvl != HV_OFF || mem_dout_en)) viol++;
            if (!mem_ce_n && !mem_oe_n && pg_pulses == 0) ev_reads++;
            if (!mem_ce_n) begin
                cur_len++;
                low_hv = mem_hv_lvl;
            end else begin
                if (!prev_ce && low_hv == HV_ERASE) begin
                    er_pulses++;
                    if (cur_len != exp_elen) bad_len++;
                    if (mem_a9_hv && mem_addr == '0 && mem_dout == 8'hFF && mem_dout_en) begin
                        for (int a = 0; a < N; a++) mem[a] = 8'hFF;
                        if (erase_left > 0) begin
                            mem[cur_efa] = 8'h7F;
                            erase_left--;
                        end
                    end
                end else if (!prev_ce && low_hv == HV_PROG) begin
                    pg_pulses++;
                    if (cur_len != exp_plen) bad_len++;
                    if (weak_left > 0 && mem_addr == cur_wa) weak_left--;
                    else if (mem_dout_en) mem[mem_addr] = mem[mem_addr] & mem_dout;
                end
                cur_len = 0;
            end
            prev_ce = mem_ce_n;
        end
    end

    // Source stream index and gap counter.
    always @(posedge clk) begin
        if (clr_req) begin
            idx <= 0;
            cyc <= '0;
        end else begin
            cyc <= cyc + 1'b1;
            if (src_valid && src_ready) idx <= idx + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            if (done || error) break;
            @(negedge clk);
        end
    endtask

    task automatic setup(input case_t c);
        cur_seed = c.seed; cur_wa = c.wa; cur_wcnt = int'(c.wcnt);
        cur_ef = int'(c.ef); cur_efa = c.efa; cur_gap = c.gap;
        cfg_retry_max = c.rty; cfg_prog_len = c.plen; cfg_erase_len = c.elen;
        exp_plen = (c.plen == 0) ? 1 : int'(c.plen);
        exp_elen = (c.elen == 0) ? 1 : int'(c.elen);
        @(negedge clk); clr_req = 1'b1;
        repeat (2) @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic run_case(input case_t c);
        int eff_w, e_er, e_pg, e_cons, e_ev, e_err;
        logic [2:0] e_addr;
        setup(c);
        do_start();
        wait_end();
        eff_w  = (stream_byte(c.seed, int'(c.wa)) == 8'hFF) ? 0 : int'(c.wcnt);
        e_addr = '0;
        if (c.ef >= 2) begin
            e_err = 1; e_addr = c.efa; e_er = 2; e_pg = 0; e_cons = 0;
            e_ev = 4 * (int'(c.efa) + 1);
        end else begin
            e_er = int'(c.ef) + 1;
            e_ev = 2 * (((c.ef == 1) ? int'(c.efa) + 1 : 0) + N);
            if (eff_w > int'(c.rty)) begin
                e_err = 1; e_addr = c.wa; e_cons = int'(c.wa) + 1;
                e_pg = int'(c.wa) + int'(c.rty) + 1;
            end else begin
                e_err = 0; e_cons = N; e_pg = N + eff_w;
            end
        end
        chk("R8 done flag", int'(done), 1 - e_err);
        chk("R7 error flag", int'(error), e_err);
        if (e_err == 1) chk("R3 R7 err_addr", int'(err_addr), int'(e_addr));
        chk("R1 R3 erase pulse count", er_pulses, e_er);
        chk("R2 erase check read cycles", ev_reads, e_ev);
        chk("R5 R6 program pulse count", pg_pulses, e_pg);
        chk("R1 R5 pulse widths wrong", bad_len, 0);
        chk("R4 bytes taken", idx, e_cons);
        chk("R9 R2 read under drive", viol, 0);
        if (e_err == 0)
            for (int a = 0; a < N; a++)
                chk("R5 R6 final contents", int'(mem[a]), int'(stream_byte(c.seed, a)));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int pulses_before;
        repeat (3) @(negedge clk);
        // R10: reset state at power-up
        chk("R10 ce_n at reset", int'(mem_ce_n), 1);
        chk("R10 oe_n at reset", int'(mem_oe_n), 1);
        chk("R10 hv level at reset", int'(mem_hv_lvl), 0);
        chk("R10 flags at reset", int'({done, error, src_ready, mem_dout_en}), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NC; k++) run_case(CASES[k]);

        // R7: after a failure nothing further happens
        run_case(CASES[2]);
        pulses_before = pg_pulses + er_pulses;
        repeat (30) @(negedge clk);
        chk("R7 no pulses after error", pg_pulses + er_pulses, pulses_before);
        chk("R7 error held", int'(error), 1);
        chk("R7 source idle after error", int'(src_ready), 0);

        // R11: a second start during the erase pulse is ignored
        setup('{8'h21, 3'd0, 4'd0, 2'd0, 3'd0, 4'd1, 16'd2, 16'd10, 1'b0});
        do_start();
        repeat (3) @(negedge clk);
        do_start();
        wait_end();
        chk("R11 single erase pulse", er_pulses, 1);
        chk("R11 run completes", int'(done), 1);
        chk("R11 bytes taken", idx, N);

        // R8: done holds while idle, then drops one cycle after a new start
        pulses_before = pg_pulses;
        repeat (30) @(negedge clk);
        chk("R8 done held", int'(done), 1);
        chk("R8 no pulses while done", pg_pulses, pulses_before);
        do_start();
        chk("R8 done cleared by start", int'(done), 0);
        chk("R8 error clear after start", int'(error), 0);
        wait_end();
        chk("R8 second run done", int'(done), 1);

        // R10: reset in the middle of programming
        setup('{8'h66, 3'd0, 4'd0, 2'd0, 3'd0, 4'd1, 16'd6, 16'd2, 1'b0});
        do_start();
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 ce_n in reset", int'(mem_ce_n), 1);
        chk("R10 oe_n in reset", int'(mem_oe_n), 1);
        chk("R10 hv level in reset", int'(mem_hv_lvl), 0);
        chk("R10 flags in reset", int'({done, error, src_ready, mem_dout_en}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 stays idle after reset", int'(mem_ce_n), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule